// File: doc/BRIEF.md
# Byte-Lane Word Store with Flow-Through Read Port

This block is the data path behind a synchronous word store whose words are split into byte lanes. Each lane holds eight data bits and one parity bit. On every clock edge, the block samples four things from the address sequencer: a cycle-valid flag, a word address, the write controls and the lane enables. It then turns the write controls into a per-lane write mask. If any lane is selected, it stores the data present on the shared bidirectional bus into those lanes.

Reads are flow-through. The address captured on an edge selects a word that reaches the bus through combinational logic during the same cycle, with no output register in between. An asynchronous active-low output enable gates the bus drivers. The drivers can only turn on in a read cycle, and raising the enable turns them off at once, without waiting for a clock.

A small cycle-state machine records what the last edge started. It has three states:

- **ST_IDLE**: entered from reset, and whenever the valid flag is low at an edge.
- **ST_READ**: entered at a valid edge with an empty write mask.
- **ST_WRITE**: entered at a valid edge with a non-empty write mask.

Every state can move to every other state at each edge. The three transitions are named go-idle, go-read and go-write.

Top module: `sram_lane_datapath`

## Requirements
- R1: After reset the state is ST_IDLE and every bit of `dq` is high-Z.
- R2: With `cyc_vld` high and `gw_n` low, all lanes of the word at `addr` take the `dq` data, whatever `bwe_n` and `lane_n` are.
- R3: With `gw_n` high and `bwe_n` low, exactly the lanes i with `lane_n[i]` low are written, in any combination. Lane i occupies `dq[9i+8:9i]`, and bit 9i+8 is that lane's parity bit.
- R4: With `gw_n` high, `bwe_n` low and `lane_n` all ones, the cycle is a read and no lane changes.
- R5: With `gw_n` and `bwe_n` both high, the cycle is a read whatever `lane_n` is, and no lane changes.
- R6: After a read edge with `oe_n` low, all lanes drive the word at the address sampled on that edge, during that same cycle.
- R7: During a write cycle every bit of `dq` is high-Z.
- R8: While `oe_n` is high, `dq` is high-Z at any time. Lowering `oe_n` during a read cycle drives the data without waiting for a clock edge.
- R9: A read that follows a partial write to the same address returns the newly written lanes merged with the lanes that were left untouched.
- R10: An edge with `cyc_vld` low writes nothing, even with `gw_n` low, and leaves `dq` high-Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the cycle state |
| cyc_vld | input | 1 | Sequencer marks this edge as an active cycle |
| addr | input | AW | Word address from the sequencer |
| gw_n | input | 1 | All-lane write, active low |
| bwe_n | input | 1 | Lane-qualified write, active low |
| lane_n | input | LANES | Per-lane enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench builds the block with four lanes of nine bits each and a depth of eight words. At that depth, the lowest and highest word can both be written and read in a handful of cycles, so address decoding at both ends of the range is checked without long runs. Nine-bit lanes put a parity bit at the top of each lane. Because of that, a lane-boundary or lane-mask fault corrupts a value the bench can see, including on the parity bits. The shallow array lets the bench keep a full word-by-word model and compare each read against it.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/lane_mask_decode.sv
module lane_mask_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] wr_mask
);

    // Priority: the all-lane write overrides any lane qualification.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_mask[g] = ~gw_n | (~bwe_n & ~lane_n[g]);
    end

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Flow-through: the row select feeds the output without a register.
    assign rdata = cells[raddr];

endmodule

// File: rtl/word_array.sv
module word_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] lane_we,
    input  logic [AW-1:0]    waddr,
    input  logic [WW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        lane_bank #(
            .LANE_W (LANE_W),
            .DEPTH  (DEPTH)
        ) u_bank (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (waddr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .raddr (raddr),
            .rdata (rdata[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/bus_driver.sv
module bus_driver #(
    parameter int W = 36
) (
    input  logic         drive_en,
    input  logic [W-1:0] drive_data,
    output logic [W-1:0] bus_in,
    inout  wire  [W-1:0] bus
);

    assign bus    = drive_en ? drive_data : {W{1'bz}};
    assign bus_in = bus;

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_vld,
    input  logic [AW-1:0]    addr,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    inout  wire  [WW-1:0]    dq
);
    import sram_dp_pkg::*;

    cyc_state_e       state_q;
    cyc_state_e       state_d;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] wr_mask;
    logic [LANES-1:0] lane_we;
    logic [WW-1:0]    bus_in;
    logic [WW-1:0]    rd_word;
    logic             dq_oe;

    lane_mask_decode #(
        .LANES (LANES)
    ) u_decode (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .lane_n  (lane_n),
        .wr_mask (wr_mask)
    );

    // Next-state and array write strobes.
    always_comb begin
        state_d = ST_IDLE;
        lane_we = '0;
        if (cyc_vld) begin
            if (|wr_mask) begin
                state_d = ST_WRITE;
                lane_we = wr_mask;
            end else begin
                state_d = ST_READ;
            end
        end
    end

    // State register and captured address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cyc_vld) begin
                addr_q <= addr;
            end
        end
    end

    word_array #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .DEPTH  (DEPTH)
    ) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (addr),
        .wdata   (bus_in),
        .raddr   (addr_q),
        .rdata   (rd_word)
    );

    // Output process: drivers on only in a read cycle with oe_n low.
    always_comb begin
        unique case (state_q)
            ST_READ:  dq_oe = ~oe_n;
            ST_WRITE: dq_oe = 1'b0;
            default:  dq_oe = 1'b0;
        endcase
    end

    bus_driver #(
        .W (WW)
    ) u_drv (
        .drive_en   (dq_oe),
        .drive_data (rd_word),
        .bus_in     (bus_in),
        .bus        (dq)
    );

    AST_GW_FORCES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && !gw_n) |=> (state_q == ST_WRITE)); // R2
    AST_EMPTY_MASK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && gw_n && !bwe_n && (&lane_n)) |=> (state_q == ST_READ)); // R4
    AST_NO_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && gw_n && bwe_n) |=> (state_q == ST_READ)); // R5
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && !oe_n) |-> dq_oe); // R6
    AST_WRITE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> !dq_oe); // R7
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R8
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_vld |=> (state_q == ST_IDLE && !dq_oe)); // R10

endmodule

// File: tb/sram_lane_datapath_bench.sv
`timescale 1ns/1ps
module sram_lane_datapath_bench;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 8;
    localparam int AW     = $clog2(DEPTH);
    localparam int WW     = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cyc_vld;
    logic [AW-1:0]    addr;
    logic             gw_n;
    logic             bwe_n;
    logic [LANES-1:0] lane_n;
    logic             oe_n;
    logic             tb_en;
    logic [WW-1:0]    tb_d;
    wire  [WW-1:0]    dq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [WW-1:0] model [DEPTH];
    localparam logic [WW-1:0] ZZ = {WW{1'bz}};

    assign dq = tb_en ? tb_d : {WW{1'bz}};

    always #2.5 clk = ~clk;

    sram_lane_datapath #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .DEPTH  (DEPTH)
    ) u_sram_lane_datapath (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_vld (cyc_vld),
        .addr    (addr),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .lane_n  (lane_n),
        .oe_n    (oe_n),
        .dq      (dq)
    );

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write-type cycle: the bench drives dq across the edge, then releases it.
    task automatic do_write(input logic [AW-1:0] a, input logic gw, input logic bw,
                            input logic [LANES-1:0] ln, input logic [WW-1:0] d,
                            input string req);
        @(negedge clk);
        cyc_vld = 1'b1; addr = a; gw_n = gw; bwe_n = bw; lane_n = ln;
        oe_n = 1'b1; tb_d = d; tb_en = 1'b1;
        @(posedge clk);
        #1 tb_en = 1'b0;
        #1 check({req, " bus high-Z in write (R7)"}, dq, ZZ);
        for (int i = 0; i < LANES; i++) begin
            if (!gw || (!bw && !ln[i])) model[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic gw, input logic bw,
                           input logic [LANES-1:0] ln, input string req);
        @(negedge clk);
        cyc_vld = 1'b1; addr = a; gw_n = gw; bwe_n = bw; lane_n = ln;
        oe_n = 1'b0; tb_en = 1'b0;
        @(posedge clk);
        #2 check(req, dq, model[a]);
    endtask

    task automatic t_reset;
        #1 check("R1 reset high-Z", dq, ZZ);
    endtask

    task automatic t_global_write;
        do_write(3'd3, 1'b0, 1'b1, 4'b1111, 36'h1_2345_6789, "R2");
        do_read(3'd3, 1'b1, 1'b1, 4'b1111, "R2 all lanes written / R6");
        do_write(3'd4, 1'b0, 1'b0, 4'b0101, 36'hF_0F0F_0F0F, "R2");
        do_read(3'd4, 1'b1, 1'b1, 4'b0000, "R2 gw overrides lanes");
    endtask

    task automatic t_byte_write;
        do_write(3'd3, 1'b1, 1'b0, 4'b1010, 36'hA_BCDE_F012, "R3");
        do_read(3'd3, 1'b1, 1'b1, 4'b1111, "R3 R9 lanes 0,2 merged");
        do_write(3'd0, 1'b0, 1'b1, 4'b1111, 36'h0_0000_0000, "R3");
        do_write(3'd0, 1'b1, 1'b0, 4'b0111, 36'hF_FFFF_FFFF, "R3");
        do_read(3'd0, 1'b1, 1'b1, 4'b1111, "R3 lane 3 with parity at row 0");
        do_write(3'd7, 1'b0, 1'b1, 4'b1111, 36'h5_5555_5555, "R3");
        do_write(3'd7, 1'b1, 1'b0, 4'b1101, 36'hA_AAAA_AAAA, "R3");
        do_read(3'd7, 1'b1, 1'b1, 4'b1111, "R3 R9 lane 1 at last row");
    endtask

    task automatic t_no_write_reads;
        // R4: lane-qualified write with no lane selected is a read.
        do_read(3'd3, 1'b1, 1'b0, 4'b1111, "R4 empty mask reads");
        do_read(3'd3, 1'b1, 1'b1, 4'b1111, "R4 row unchanged");
        // R5: lanes enabled but both write controls high.
        do_read(3'd4, 1'b1, 1'b1, 4'b0000, "R5 lanes ignored");
        do_read(3'd4, 1'b1, 1'b1, 4'b1111, "R5 row unchanged");
    endtask

    task automatic t_flow_through;
        do_read(3'd0, 1'b1, 1'b1, 4'b1111, "R6 row 0");
        do_read(3'd7, 1'b1, 1'b1, 4'b1111, "R6 row 7 next cycle");
        do_read(3'd3, 1'b1, 1'b1, 4'b1111, "R6 row 3 next cycle");
    endtask

    task automatic t_output_enable;
        do_read(3'd4, 1'b1, 1'b1, 4'b1111, "R8 setup read");
        oe_n = 1'b1;
        #0.5 check("R8 oe high mid-cycle", dq, ZZ);
        oe_n = 1'b0;
        #0.5 check("R8 oe low drives without edge", dq, model[4]);
        @(negedge clk);
        cyc_vld = 1'b1; addr = 3'd7; gw_n = 1'b1; bwe_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        #2 check("R8 read with oe high", dq, ZZ);
    endtask

    task automatic t_deselect;
        @(negedge clk);
        cyc_vld = 1'b0; addr = 3'd3; gw_n = 1'b0; bwe_n = 1'b0; lane_n = 4'b0000;
        oe_n = 1'b1; tb_d = 36'h0_DEAD_BEEF; tb_en = 1'b1;
        @(posedge clk);
        #1 tb_en = 1'b0;
        oe_n = 1'b0;
        #1 check("R10 deselect high-Z", dq, ZZ);
        do_read(3'd3, 1'b1, 1'b1, 4'b1111, "R10 no write on deselect");
    endtask

    initial begin
        rst_n = 1'b0; cyc_vld = 1'b0; addr = '0; gw_n = 1'b1; bwe_n = 1'b1;
        lane_n = '1; oe_n = 1'b0; tb_en = 1'b0; tb_d = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        // Clear every row so the model matches the array.
        for (int i = 0; i < DEPTH; i++) do_write(i[AW-1:0], 1'b0, 1'b1, 4'b1111, '0, "init");
        t_global_write();
        t_byte_write();
        t_no_write_reads();
        t_flow_through();
        t_output_enable();
        t_deselect();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule